// File: doc/BRIEF.md
# Interrupt Claim and Completion Controller

This block gathers interrupt requests from a set of numbered sources and forwards at most one interrupt line to a single target. Each source has a pending bit, an enable bit, a programmable priority and an in-service bit. A combinational selector finds the best candidate: a source that is pending, enabled, not in service and has non-zero priority. When that candidate's priority is strictly above a programmable threshold, the target's interrupt line is raised.

Software uses a small word-addressed register port. A read of the claim/complete register returns the selected source ID and, at the same clock edge, takes that source: pending clears and in-service sets. A later write of the same ID to that register ends the service. A completion is honoured only while the named source is still enabled. A completion for a masked source is dropped, so the source stays in service until a completion arrives while it is enabled. A build option can make every claim also clear the claimed source's enable bit.

Top module: `irq_claim_gate`

## Requirements
- R1: After reset all pending, enable, in-service, priority and threshold state is zero, `irqOut` is low and a claim read returns 0.
- R2: A claim read (address 0x42) returns the ID of the pending, enabled, not-in-service source with the highest non-zero priority in the same cycle, or 0 when there is none. Sources are numbered 1 to NUM_SRC, and among equal priorities the lowest ID wins.
- R3: At the clock edge that ends a claim read returning a non-zero ID, the pending bit of that source clears and its in-service bit sets.
- R4: An in-service source is never returned by a claim and never raises `irqOut`. A request that arrives while the source is in service still sets its pending bit.
- R5: A completion write of an ID whose enable bit is set clears that source's in-service bit. A completion write for a source whose enable bit is clear changes nothing.
- R6: A completion write of 0, or of any value above NUM_SRC, has no effect.
- R7: `irqOut` is high exactly when the best candidate's priority is strictly greater than the threshold.
- R8: With MASK_ON_CLAIM=1 a claim also clears the enable bit of the claimed source. With the default MASK_ON_CLAIM=0 a claim leaves enable bits unchanged.
- R9: The register map is as follows. Addresses 1 to NUM_SRC hold the PRIO_W-bit priority of that source. Address 0x40 holds the enables, with bit k-1 for source k. Address 0x41 holds the threshold. Address 0x42 is claim/complete. Address 0x43 holds the pending bits (read-only), with bit k-1 for source k. Unmapped addresses and unused bits read as 0.
- R10: A one-cycle pulse on `irqReq[k-1]` sets the pending bit of source k at that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_SRC | Request pulses; bit k-1 belongs to source k |
| rdEn | input | 1 | Register read strobe (claim side effect at address 0x42) |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle of `rdEn` |
| irqOut | output | 1 | Interrupt line to the target |

## Verification
The hardest state to reach is the stuck source. To get there, a source is claimed, then masked, then sent a completion that gets dropped, and then sent a fresh request while it is still in service. The vector table walks this sequence in order. It shows that the new request is visible in the pending register, yet no claim returns it and `irqOut` stays low. Only after the source is re-enabled and a second completion is written does the source come back. Threshold equality and priority ties are reached from the same table by programming two sources with equal priority and setting the threshold equal to that priority.

// File: rtl/irq_claim_gate_pkg.sv
package irq_claim_gate_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] REG_ENABLE = 8'h40;
  localparam logic [ADDR_W-1:0] REG_THRESH = 8'h41;
  localparam logic [ADDR_W-1:0] REG_CLAIM  = 8'h42;
  localparam logic [ADDR_W-1:0] REG_PEND   = 8'h43;

  // strobes from register decode into the state datapath
  typedef struct packed {
    logic prioWr;
    logic enableWr;
    logic threshWr;
    logic claimRd;
    logic completeWr;
  } gate_strobe_t;
endpackage

// File: rtl/irq_claim_gate_ctl.sv
module irq_claim_gate_ctl
  import irq_claim_gate_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 4
) (
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output gate_strobe_t      stb,
  output logic [ID_W-1:0]   cplId
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_SRC);
  localparam logic [ID_W-1:0]   LAST_ID   = ID_W'(NUM_SRC);

  logic cplIdOk;

  assign cplId   = wrData[ID_W-1:0];
  assign cplIdOk = (wrData[DATA_W-1:ID_W] == '0) && (cplId != '0) && (cplId <= LAST_ID);

  always_comb begin
    stb            = '0;
    stb.prioWr     = wrEn && (addr != '0) && (addr <= LAST_ADDR);
    stb.enableWr   = wrEn && (addr == REG_ENABLE);
    stb.threshWr   = wrEn && (addr == REG_THRESH);
    stb.claimRd    = rdEn && (addr == REG_CLAIM);
    stb.completeWr = wrEn && (addr == REG_CLAIM) && cplIdOk;
  end
endmodule

// File: rtl/irq_claim_gate_pick.sv
module irq_claim_gate_pick #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 4
) (
  input  logic [NUM_SRC-1:0]             eligible,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prioArr,
  output logic [ID_W-1:0]                bestId,
  output logic [PRIO_W-1:0]              bestPrio
);
  // strict greater-than while scanning upward keeps the lowest ID on ties
  always_comb begin
    bestId   = '0;
    bestPrio = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (eligible[s] && (prioArr[s] > bestPrio)) begin
        bestPrio = prioArr[s];
        bestId   = ID_W'(s + 1);
      end
    end
  end
endmodule

// File: rtl/irq_claim_gate_dp.sv
module irq_claim_gate_dp
  import irq_claim_gate_pkg::*;
#(
  parameter int NUM_SRC       = 8,
  parameter int PRIO_W        = 3,
  parameter int ID_W          = 4,
  parameter int PASS_W        = 8,
  parameter bit MASK_ON_CLAIM = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  gate_strobe_t      stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PASS_W-1:0] wrLow,
  input  logic [ID_W-1:0]   cplId,
  input  logic [NUM_SRC-1:0] irqReq,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic [ID_W-1:0]   bestId,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] enVec,
  output logic [NUM_SRC-1:0] svcVec
);
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioArr;
  logic [NUM_SRC-1:0]             eligible;
  logic [PRIO_W-1:0]              bestPrio;
  logic [PRIO_W-1:0]              threshQ;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam logic [ID_W-1:0]   SID   = ID_W'(s + 1);
    localparam logic [ADDR_W-1:0] SADDR = ADDR_W'(s + 1);

    logic              pendQ, enQ, svcQ;
    logic [PRIO_W-1:0] prioQ;
    logic              hitClaim, hitCpl;

    assign hitClaim = stb.claimRd && (bestId == SID);
    assign hitCpl   = stb.completeWr && (cplId == SID) && enQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ <= 1'b0;
        enQ   <= 1'b0;
        svcQ  <= 1'b0;
        prioQ <= '0;
      end else begin
        if (hitClaim)       pendQ <= 1'b0;
        else if (irqReq[s]) pendQ <= 1'b1;

        if (hitClaim)    svcQ <= 1'b1;
        else if (hitCpl) svcQ <= 1'b0;

        if (stb.enableWr)                  enQ <= wrLow[s];
        else if (MASK_ON_CLAIM && hitClaim) enQ <= 1'b0;

        if (stb.prioWr && (addr == SADDR)) prioQ <= wrLow[PRIO_W-1:0];
      end
    end

    assign pendVec[s]  = pendQ;
    assign enVec[s]    = enQ;
    assign svcVec[s]   = svcQ;
    assign prioArr[s]  = prioQ;
    assign eligible[s] = pendQ && enQ && !svcQ && (prioQ != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             threshQ <= '0;
    else if (stb.threshWr) threshQ <= wrLow[PRIO_W-1:0];
  end

  irq_claim_gate_pick #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
  ) u_pick (
    .eligible(eligible),
    .prioArr (prioArr),
    .bestId  (bestId),
    .bestPrio(bestPrio)
  );

  assign irqOut = (bestPrio > threshQ);

  always_comb begin
    rdData = '0;
    case (addr)
      REG_ENABLE: rdData[NUM_SRC-1:0] = enVec;
      REG_THRESH: rdData[PRIO_W-1:0]  = threshQ;
      REG_CLAIM:  rdData[ID_W-1:0]    = bestId;
      REG_PEND:   rdData[NUM_SRC-1:0] = pendVec;
      default: begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (addr == ADDR_W'(s + 1)) rdData[PRIO_W-1:0] = prioArr[s];
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_claim_gate.sv
module irq_claim_gate
  import irq_claim_gate_pkg::*;
#(
  parameter int NUM_SRC       = 8,
  parameter int PRIO_W        = 3,
  parameter bit MASK_ON_CLAIM = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  localparam int ID_W   = $clog2(NUM_SRC + 1);
  localparam int PASS_W = (NUM_SRC > PRIO_W) ? NUM_SRC : PRIO_W;

  gate_strobe_t       stb;
  logic [ID_W-1:0]    cplId;
  logic [ID_W-1:0]    bestId;
  logic [NUM_SRC-1:0] pendVec, enVec, svcVec;

  irq_claim_gate_ctl #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_ctl (
    .rdEn  (rdEn),
    .wrEn  (wrEn),
    .addr  (addr),
    .wrData(wrData),
    .stb   (stb),
    .cplId (cplId)
  );

  irq_claim_gate_dp #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W),
    .PASS_W(PASS_W), .MASK_ON_CLAIM(MASK_ON_CLAIM)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .addr   (addr),
    .wrLow  (wrData[PASS_W-1:0]),
    .cplId  (cplId),
    .irqReq (irqReq),
    .rdData (rdData),
    .irqOut (irqOut),
    .bestId (bestId),
    .pendVec(pendVec),
    .enVec  (enVec),
    .svcVec (svcVec)
  );
endmodule

// File: rtl/irq_claim_gate_chk.sv
module irq_claim_gate_chk
  import irq_claim_gate_pkg::*;
#(
  parameter int NUM_SRC       = 8,
  parameter int ID_W          = 4,
  parameter bit MASK_ON_CLAIM = 1'b0
) (
  input logic               clk,
  input logic               rstN,
  input logic               rdEn,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input logic               irqOut,
  input logic [ID_W-1:0]    bestId,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [NUM_SRC-1:0] enVec,
  input logic [NUM_SRC-1:0] svcVec
);
  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_SRC);

  logic               claimNow, cplWrite, cplInRange;
  logic [ID_W-1:0]    cplIdW;
  logic [NUM_SRC-1:0] claimMask, cplMask;

  assign claimNow   = rdEn && (addr == REG_CLAIM) && (bestId != '0);
  assign cplWrite   = wrEn && !rdEn && (addr == REG_CLAIM);
  assign cplIdW     = wrData[ID_W-1:0];
  assign cplInRange = (wrData[DATA_W-1:ID_W] == '0) && (cplIdW != '0) && (cplIdW <= LAST_ID);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      claimMask[i] = (bestId == ID_W'(i + 1));
      cplMask[i]   = (cplIdW == ID_W'(i + 1));
    end
  end

  AST_CLAIM_TAKES_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    claimNow |=> ((svcVec & $past(claimMask)) == $past(claimMask)) && ((pendVec & $past(claimMask)) == '0)); // R3

  AST_CLAIM_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rstN)
    claimNow |=> (bestId != $past(bestId))); // R4

  AST_MASKED_CPL_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (cplWrite && cplInRange && ((enVec & cplMask) == '0)) |=> $stable(svcVec)); // R5

  AST_BAD_ID_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (cplWrite && !cplInRange) |=> $stable(svcVec)); // R6

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (bestId != '0)); // R7

  AST_MASK_ON_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    (claimNow && MASK_ON_CLAIM && !(wrEn && addr == REG_ENABLE)) |=> ((enVec & $past(claimMask)) == '0)); // R8
endmodule

bind irq_claim_gate irq_claim_gate_chk #(
  .NUM_SRC(NUM_SRC), .ID_W(ID_W), .MASK_ON_CLAIM(MASK_ON_CLAIM)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .rdEn   (rdEn),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .irqOut (irqOut),
  .bestId (bestId),
  .pendVec(pendVec),
  .enVec  (enVec),
  .svcVec (svcVec)
);

// File: tb/irq_claim_gate_bench.sv
`timescale 1ns/1ps
module irq_claim_gate_bench;
  localparam int NSRC = 8;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_REQ = 2'd2, OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 55;
  localparam vec_t VECS [NVEC] = '{
    '{OP_WR,  8'h03, 32'h5,  4'd9},  // prio src3 = 5
    '{OP_WR,  8'h05, 32'h5,  4'd9},  // prio src5 = 5
    '{OP_WR,  8'h02, 32'h2,  4'd9},  // prio src2 = 2
    '{OP_WR,  8'h40, 32'h16, 4'd9},  // enable 2,3,5
    '{OP_WR,  8'h41, 32'h1,  4'd9},  // threshold 1
    '{OP_REQ, 8'h00, 32'h16, 4'd10}, // R10 requests 2,3,5
    '{OP_IRQ, 8'h00, 32'h1,  4'd7},
    '{OP_RD,  8'h43, 32'h16, 4'd10},
    '{OP_RD,  8'h42, 32'h3,  4'd2},  // R2 tie 3 vs 5 -> 3
    '{OP_RD,  8'h43, 32'h12, 4'd3},  // R3 pending of 3 cleared
    '{OP_RD,  8'h42, 32'h5,  4'd2},
    '{OP_RD,  8'h42, 32'h2,  4'd2},
    '{OP_RD,  8'h42, 32'h0,  4'd2},
    '{OP_IRQ, 8'h00, 32'h0,  4'd4},
    '{OP_REQ, 8'h00, 32'h04, 4'd4},  // R4 request while in service
    '{OP_RD,  8'h43, 32'h04, 4'd4},
    '{OP_IRQ, 8'h00, 32'h0,  4'd4},
    '{OP_WR,  8'h42, 32'h3,  4'd5},  // R5 complete 3
    '{OP_IRQ, 8'h00, 32'h1,  4'd5},
    '{OP_RD,  8'h42, 32'h3,  4'd5},
    '{OP_RD,  8'h43, 32'h0,  4'd3},
    '{OP_WR,  8'h42, 32'h5,  4'd5},  // complete 5
    '{OP_WR,  8'h41, 32'h5,  4'd7},  // threshold equal to prio
    '{OP_REQ, 8'h00, 32'h10, 4'd10},
    '{OP_IRQ, 8'h00, 32'h0,  4'd7},  // R7 not strictly above
    '{OP_WR,  8'h41, 32'h4,  4'd7},
    '{OP_IRQ, 8'h00, 32'h1,  4'd7},
    '{OP_RD,  8'h42, 32'h5,  4'd2},
    '{OP_WR,  8'h40, 32'h06, 4'd5},  // mask 5
    '{OP_WR,  8'h42, 32'h5,  4'd5},  // dropped completion
    '{OP_WR,  8'h40, 32'h16, 4'd5},  // unmask 5
    '{OP_REQ, 8'h00, 32'h10, 4'd4},
    '{OP_RD,  8'h43, 32'h10, 4'd4},
    '{OP_IRQ, 8'h00, 32'h0,  4'd5},  // R5 still stuck in service
    '{OP_RD,  8'h42, 32'h0,  4'd5},
    '{OP_WR,  8'h42, 32'h5,  4'd5},  // completion while enabled
    '{OP_IRQ, 8'h00, 32'h1,  4'd5},
    '{OP_RD,  8'h42, 32'h5,  4'd5},
    '{OP_WR,  8'h41, 32'h1,  4'd9},
    '{OP_REQ, 8'h00, 32'h02, 4'd4},
    '{OP_WR,  8'h42, 32'h0,  4'd6},  // R6 ID 0
    '{OP_WR,  8'h42, 32'h9,  4'd6},  // R6 ID above range
    '{OP_IRQ, 8'h00, 32'h0,  4'd6},
    '{OP_RD,  8'h42, 32'h0,  4'd6},
    '{OP_WR,  8'h42, 32'h2,  4'd5},
    '{OP_IRQ, 8'h00, 32'h1,  4'd7},
    '{OP_RD,  8'h42, 32'h2,  4'd2},
    '{OP_WR,  8'h04, 32'h0,  4'd2},  // src4 prio 0
    '{OP_WR,  8'h40, 32'h1E, 4'd9},
    '{OP_REQ, 8'h00, 32'h08, 4'd10},
    '{OP_RD,  8'h43, 32'h08, 4'd10},
    '{OP_IRQ, 8'h00, 32'h0,  4'd2},  // R2 prio 0 never interrupts
    '{OP_RD,  8'h42, 32'h0,  4'd2},
    '{OP_RD,  8'h40, 32'h1E, 4'd8},  // R8 no mask on claim by default
    '{OP_RD,  8'h03, 32'h5,  4'd9}   // R9 priority readback
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [NSRC-1:0] irqReq = '0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int nVec = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  irq_claim_gate #(.NUM_SRC(NSRC), .PRIO_W(3), .MASK_ON_CLAIM(1'b0)) u_irq_claim_gate (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .rdEn(rdEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1 wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    #5 d = rdData;
    @(posedge clk); #1 rdEn = 1'b0;
  endtask

  task automatic pulseReq(input logic [NSRC-1:0] m);
    @(negedge clk); irqReq = m;
    @(posedge clk); #1 irqReq = '0;
  endtask

  task automatic sampleIrq(output logic v);
    @(negedge clk); #5 v = irqOut;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rv;
    logic        iv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    sampleIrq(iv);        check("R1 irq", {31'd0, iv}, 32'd0);
    regRead(8'h42, rv);   check("R1 claim", rv, 32'd0);
    regRead(8'h40, rv);   check("R1 enable", rv, 32'd0);
    regRead(8'h43, rv);   check("R1 pending", rv, 32'd0);
    regRead(8'h41, rv);   check("R1 threshold", rv, 32'd0);
    regRead(8'h01, rv);   check("R1 priority", rv, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      case (VECS[i].op)
        OP_WR:  regWrite(VECS[i].addr, VECS[i].data);
        OP_RD:  begin regRead(VECS[i].addr, rv); check(tag, rv, VECS[i].data); end
        OP_REQ: pulseReq(VECS[i].data[NSRC-1:0]);
        default: begin sampleIrq(iv); check(tag, {31'd0, iv}, VECS[i].data); end
      endcase
    end

    // R9 unused enable bits and unmapped address read zero
    regWrite(8'h40, 32'hFFFF);
    regRead(8'h40, rv);   check("R9 enable width", rv, 32'h0000_00FF);
    regRead(8'h00, rv);   check("R9 address 0", rv, 32'd0);
    regRead(8'h41, rv);   check("R9 threshold", rv, 32'd1);

    // R1 reset mid-run clears state
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    regRead(8'h43, rv);   check("R1 pending after reset", rv, 32'd0);
    sampleIrq(iv);        check("R1 irq after reset", {31'd0, iv}, 32'd0);

    finishRun();
  end
endmodule